// File: doc/BRIEF.md
# Reloadable Event Down-Counter Timer Bank

This block is a bank of 16-bit down-counting timers, each of which decrements once per count event. For each timer, software picks the event source. It can be a selected edge of that timer's own external input pin. It can instead be the underflow pulse of a fixed neighbour timer, which lets timers cascade into longer dividers. When a timer at zero receives an event, it reloads from its reload register, raises a one-cycle interrupt request and keeps counting. A programmed value n therefore divides the event rate by n+1.

A single register port serves the whole bank. A write selects one timer and always updates its reload register. The write also lands in the counter while that timer is stopped, and after a start until the first event arrives. From then on the counter takes the new value only at its next reload. A read selects one timer and returns its live count. If a write that reaches the counter coincides with an event in the same cycle, the written value wins.

Top module: `evt_timer_bank`

## Requirements
- R1: While its run bit is 1, a timer's counter decreases by exactly one for each qualified event and never increases except by reload or write.
- R2: An event that finds the counter at 0 loads the reload value into the counter, counting continues, and the timer's irq bit is 1 in the following cycle.
- R3: With value n programmed, exactly one irq occurs per n+1 events (n = 0 gives an irq on every event; n = FFFFh leaves the count at FFFEh after one event).
- R4: While the run bit is 0, events are ignored and the counter keeps its value.
- R5: While the run bit is 0, and after a 0-to-1 change of the run bit until the first counted event, a write sets both the reload register and the counter.
- R6: After the first counted event following a start, a write changes only the reload register, and the counter takes the new value at its next reload.
- R7: Each 0-to-1 change of the run bit re-arms the behaviour of R5, even if events were counted before the stop.
- R8: The edge mode field of timer i is edge_mode[2i+1:2i]: 00 counts rising edges, 01 falling edges, 10 both edges and 11 counts nothing.
- R9: The external input passes through a two-stage synchroniser. If ext_in changes just before clock edge k, the counter changes at edge k+2.
- R10: When chain_sel[i] is 1, timer i counts the irq pulses of timer i-1, with wrap-around inside groups of three: timer 0 takes timer 2 and timer 3 takes timer 5. Its own pin is ignored in this mode.
- R11: Each underflow produces an irq pulse one clock cycle wide.
- R12: rd_data returns the live counter of timer rd_sel, not its reload value.
- R13: After reset, every counter and reload register is 0 and every irq bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 6 | External event pins, one per timer |
| run | input | 6 | Run bit per timer (1 = counting) |
| chain_sel | input | 6 | Source select per timer (1 = neighbour underflow, 0 = own pin) |
| edge_mode | input | 12 | Two-bit edge mode per timer, timer i at bits 2i+1:2i |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Timer index for the write |
| wr_data | input | 16 | Write value |
| rd_sel | input | 3 | Timer index for the read |
| rd_data | output | 16 | Live count of the selected timer |
| irq | output | 6 | One-cycle underflow pulse per timer |

## Verification
The embedded properties check several rules on every cycle. An irq may only follow an event that found the counter at zero. A stopped timer without a write must hold its count. A counter may change only through an event or a write. Once armed, a write with no event must leave the counter alone. An edge pulse may only appear when the synchronised input has changed. Other behaviours need the bench's scenarios: the division ratio over long event trains, the exact two-stage synchroniser latency, re-arming after a restart, the wrap-around neighbour mapping, and the one-cycle irq width seen at the port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W    = 16;
    localparam int NUM_TMR   = 6;
    localparam int GROUP_LEN = 3;

    // Edge qualifier encoding (field value matters to software).
    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_OFF  = 2'b11
    } edge_sel_e;

    // Per-timer control bundle.
    typedef struct packed {
        logic      run;
        logic      chain;
        edge_sel_e mode;
    } tmr_ctrl_t;

    // Neighbour whose underflow feeds timer idx, wrapping inside each group.
    function automatic int chain_src(input int idx, input int grp);
        if ((idx % grp) == 0)
            return idx + grp - 1;
        else
            return idx - 1;
    endfunction

    // Qualify a synchronised sample pair against the chosen edge mode.
    function automatic logic edge_hit(input edge_sel_e mode,
                                      input logic cur, input logic prev);
        case (mode)
            EDGE_RISE: return cur & ~prev;
            EDGE_FALL: return ~cur & prev;
            EDGE_BOTH: return cur ^ prev;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  edge_sel_e mode,
    output logic      pulse
);

    logic sync_a;
    logic sync_b;
    logic hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            hist   <= 1'b0;
        end else begin
            sync_a <= pin;
            sync_b <= sync_a;
            hist   <= sync_b;
        end
    end

    always_comb pulse = edge_hit(mode, sync_b, hist);

    // R8
    pulse_needs_change_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> (sync_b != hist));

endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
    parameter int WIDTH = tmr_pkg::DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             evt,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] count,
    output logic             uf
);

    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] rld_q;
    logic             seen_q;
    logic             run_q;
    logic             step;
    logic             armed;

    always_comb begin
        step  = run & evt;
        // armed: running since before this cycle and first event counted
        armed = run & run_q & seen_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= ZERO;
            rld_q  <= ZERO;
            seen_q <= 1'b0;
            run_q  <= 1'b0;
            uf     <= 1'b0;
        end else begin
            run_q <= run;
            uf    <= 1'b0;
            if (run && !run_q)
                seen_q <= 1'b0;
            if (step) begin
                seen_q <= 1'b1;
                if (cnt_q == ZERO) begin
                    cnt_q <= rld_q;
                    uf    <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (wr) begin
                rld_q <= wdata;
                if (!armed)
                    cnt_q <= wdata;
            end
        end
    end

    assign count = cnt_q;

    // R2
    uf_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        uf |-> $past(step && cnt_q == ZERO));

    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr) |=> (cnt_q == $past(cnt_q)));

    // R6
    reload_only_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && wr && !evt) |=> (cnt_q == $past(cnt_q)));

    // R1
    change_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> $past(step || wr));

endmodule

// File: rtl/evt_timer_bank.sv
module evt_timer_bank
    import tmr_pkg::*;
#(
    parameter int WIDTH = tmr_pkg::DATA_W,
    parameter int NUM   = tmr_pkg::NUM_TMR,
    parameter int GROUP = tmr_pkg::GROUP_LEN,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM-1:0]     ext_in,
    input  logic [NUM-1:0]     run,
    input  logic [NUM-1:0]     chain_sel,
    input  logic [2*NUM-1:0]   edge_mode,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_sel,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic [IDX_W-1:0]   rd_sel,
    output logic [WIDTH-1:0]   rd_data,
    output logic [NUM-1:0]     irq
);

    logic [WIDTH-1:0] cnt_arr [NUM];
    logic [NUM-1:0]   pin_evt;
    logic [NUM-1:0]   sel_evt;
    tmr_ctrl_t        ctrl [NUM];

    for (genvar i = 0; i < NUM; i++) begin : g_tmr
        localparam int SRC = chain_src(i, GROUP);
        logic wr_hit;

        always_comb begin
            ctrl[i].run   = run[i];
            ctrl[i].chain = chain_sel[i];
            ctrl[i].mode  = edge_sel_e'(edge_mode[2*i +: 2]);
            wr_hit        = wr_en && (wr_sel == IDX_W'(i));
            sel_evt[i]    = ctrl[i].chain ? irq[SRC] : pin_evt[i];
        end

        tmr_edge_det u_edge (
            .clk   (clk),
            .rst   (rst),
            .pin   (ext_in[i]),
            .mode  (ctrl[i].mode),
            .pulse (pin_evt[i])
        );

        tmr_down_cnt #(.WIDTH(WIDTH)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .run   (ctrl[i].run),
            .evt   (sel_evt[i]),
            .wr    (wr_hit),
            .wdata (wr_data),
            .count (cnt_arr[i]),
            .uf    (irq[i])
        );

        // R10
        chain_ignores_pin_chk: assert property (@(posedge clk) disable iff (rst)
            (chain_sel[i] && !irq[SRC]) |-> !sel_evt[i]);
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM; k++)
            if (rd_sel == IDX_W'(k))
                rd_data = cnt_arr[k];
    end

endmodule

// File: tb/test_evt_timer_bank.sv
module test_evt_timer_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  ext_in;
    logic [5:0]  run;
    logic [5:0]  chain_sel;
    logic [11:0] edge_mode;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic [2:0]  rd_sel;
    logic [15:0] rd_data;
    logic [5:0]  irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int irq_tot [6];
    int hi_len [6];
    int max_len = 0;

    always #10 clk = ~clk;

    evt_timer_bank i_evt_timer_bank (
        .clk(clk), .rst(rst), .ext_in(ext_in), .run(run),
        .chain_sel(chain_sel), .edge_mode(edge_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    initial begin
        for (int k = 0; k < 6; k++) begin irq_tot[k] = 0; hi_len[k] = 0; end
    end

    always @(posedge clk) begin
        for (int k = 0; k < 6; k++) begin
            if (irq[k] === 1'b1) begin
                irq_tot[k] = irq_tot[k] + 1;
                hi_len[k]  = hi_len[k] + 1;
                if (hi_len[k] > max_len) max_len = hi_len[k];
            end else begin
                hi_len[k] = 0;
            end
        end
    end

    // {n, events, expected count, expected irqs} for timer 0, rising edges
    localparam logic [63:0] VEC [5] = '{
        {16'h0005, 16'd3,  16'h0002, 16'd0},
        {16'h0002, 16'd3,  16'h0002, 16'd1},
        {16'h0000, 16'd4,  16'h0000, 16'd4},
        {16'h0003, 16'd10, 16'h0001, 16'd2},
        {16'hFFFF, 16'd1,  16'hFFFE, 16'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input int idx, input int exp, input string req);
        @(negedge clk);
        rd_sel = 3'(idx);
        #1;
        check(req, int'(rd_data), exp);
    endtask

    task automatic reg_wr(input int idx, input logic [15:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(idx); wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        ext_in[idx] = 1'b1;
        repeat (4) @(negedge clk);
        ext_in[idx] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_run(input int idx, input logic v);
        @(negedge clk);
        run[idx] = v;
        @(negedge clk);
    endtask

    initial begin
        int base;
        rst = 1'b1; ext_in = '0; run = '0; chain_sel = '0; edge_mode = '0;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        for (int k = 0; k < 6; k++) rd_chk(k, 0, "R13 count after reset");
        check("R13 irq after reset", int'(irq), 0);

        // Vector table: R1, R2, R3, R12 on timer 0
        for (int v = 0; v < 5; v++) begin
            set_run(0, 1'b0);
            reg_wr(0, VEC[v][63:48]);
            set_run(0, 1'b1);
            base = irq_tot[0];
            for (int p = 0; p < int'(VEC[v][47:32]); p++) pulse(0);
            rd_chk(0, int'(VEC[v][31:16]), "R1/R12 vector count");
            check("R3 vector irq count", irq_tot[0] - base, int'(VEC[v][15:0]));
        end

        // R9 synchroniser latency
        set_run(0, 1'b0);
        reg_wr(0, 16'd10);
        set_run(0, 1'b1);
        @(negedge clk);
        ext_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        rd_chk(0, 10, "R9 not yet counted after two edges");
        rd_chk(0, 9, "R9 counted at third edge");
        ext_in[0] = 1'b0;
        repeat (4) @(negedge clk);

        // R6 write after first event only reaches reload
        reg_wr(0, 16'd3);
        rd_chk(0, 9, "R6 counter untouched by armed write");
        base = irq_tot[0];
        for (int p = 0; p < 10; p++) pulse(0);
        rd_chk(0, 3, "R6 new value at reload");
        check("R2 irq on reload", irq_tot[0] - base, 1);

        // R4 stopped ignores events
        set_run(0, 1'b0);
        pulse(0);
        rd_chk(0, 3, "R4 stopped holds");

        // R5 writes while stopped and before first event
        reg_wr(0, 16'd20);
        rd_chk(0, 20, "R5 stopped write");
        set_run(0, 1'b1);
        reg_wr(0, 16'd30);
        rd_chk(0, 30, "R5 write before first event");
        pulse(0);
        rd_chk(0, 29, "R1 decrement after start");

        // R7 restart re-arms
        set_run(0, 1'b0);
        set_run(0, 1'b1);
        reg_wr(0, 16'd40);
        rd_chk(0, 40, "R7 restart re-arms write");
        set_run(0, 1'b0);

        // R8 edge modes
        edge_mode[3:2] = 2'b01;
        reg_wr(1, 16'd4);
        set_run(1, 1'b1);
        @(negedge clk); ext_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk(1, 4, "R8 falling mode ignores rise");
        ext_in[1] = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk(1, 3, "R8 falling mode counts fall");
        edge_mode[5:4] = 2'b10;
        reg_wr(2, 16'd4);
        set_run(2, 1'b1);
        pulse(2);
        rd_chk(2, 2, "R8 both edges");
        edge_mode[9:8] = 2'b11;
        reg_wr(4, 16'd4);
        set_run(4, 1'b1);
        pulse(4);
        rd_chk(4, 4, "R8 mode off");

        // R10 chain timer1 from timer0
        set_run(1, 1'b0);
        chain_sel[1] = 1'b1;
        reg_wr(1, 16'd5);
        set_run(1, 1'b1);
        reg_wr(0, 16'd1);
        set_run(0, 1'b1);
        for (int p = 0; p < 4; p++) pulse(0);
        pulse(1);
        rd_chk(1, 3, "R10 chained count from timer0");

        // R10 wrap: timer3 from timer5
        edge_mode[11:10] = 2'b00;
        reg_wr(5, 16'd0);
        set_run(5, 1'b1);
        chain_sel[3] = 1'b1;
        reg_wr(3, 16'd6);
        set_run(3, 1'b1);
        for (int p = 0; p < 3; p++) pulse(5);
        rd_chk(3, 3, "R10 timer3 chained from timer5");

        // R10 wrap: timer0 from timer2
        set_run(0, 1'b0);
        set_run(2, 1'b0);
        edge_mode[5:4] = 2'b00;
        reg_wr(2, 16'd0);
        set_run(2, 1'b1);
        chain_sel[0] = 1'b1;
        reg_wr(0, 16'd2);
        set_run(0, 1'b1);
        pulse(2);
        rd_chk(0, 1, "R10 timer0 chained from timer2");

        // R11 pulse width
        check("R11 irq pulse width", max_len, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule